// File: doc/BRIEF.md
# Double-Buffer Bank Router

This block places a frame producer and a frame consumer on two separate memory banks so that they form a double buffer. The producer is a simple write master. The consumer is a read master that issues pipelined burst reads and receives its data through a data-valid strobe, possibly many cycles after each address phase. One bank-select bit steers every request signal. With the bit clear, the producer uses bank 0 and the consumer uses bank 1. With the bit set, the two are crossed over.

A swap request flips both routes on a single clock edge. The router keeps the request pending until two things hold: the consumer has reported that its frame is finished, and every read the router has accepted has returned all of its beats. The router counts outstanding beats itself. An accepted read adds its burst length to the count, and each returned beat subtracts one. While a swap is pending, the router stalls the consumer so that no new read can start after the frame has ended. The router acknowledges the completed swap with a single-cycle pulse.

Addresses pass through unchanged. Each master drives word-aligned byte addresses relative to the bank it currently owns, and no bank offset is added.

Top module: `pingpong_bank_router`

## Requirements
- R1: After reset, `bankSel` is 0, `swapAck` is 0, the producer's requests reach bank 0 only, and the consumer's requests reach bank 1 only.
- R2: The producer's write strobe, address and write data appear on the bank it owns, and the other bank sees no write from it. `wrWaitReq` equals the waitrequest of the producer's bank and ignores the other bank's waitrequest.
- R3: The consumer's read strobe, address and burst length appear on the bank it owns. `rdReadData` and `rdDataValid` come only from that bank, and a data-valid strobe from the other bank is not passed on.
- R4: Addresses reach the bank bit for bit as the master drives them, with no bank offset added. Word n is byte address 4n; for example, word 4 is driven as 0x10, and 0x7FFFFFC is the last word of a window.
- R5: A swap request made before the consumer has pulsed `frameDone` is held. `bankSel` does not change until `frameDone` has been seen.
- R6: An accepted consumer read (read high, waitrequest low) adds its burst length to an outstanding count, and each data-valid beat from the consumer's bank subtracts one. A pending swap does not take place while this count is non-zero. It takes place on the clock edge after the count reaches zero.
- R7: While a swap is pending, `rdWaitReq` is high and neither bank receives a read strobe, even if the consumer holds `rdRead` high.
- R8: A swap flips both routes on the same edge. In the first cycle with `bankSel` flipped, `swapAck` is high, the consumer's requests go to the bank the producer used before, and the producer's requests go to the bank the consumer used before. `swapAck` is low again in the next cycle.
- R9: A `frameDone` pulse with no request never causes a swap. A request made when the frame is already done and the count is zero completes on the next clock edge.
- R10: A swap clears the frame-done condition. A later request waits for a new `frameDone` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| swapReq | input | 1 | Request to exchange the banks (one-cycle pulse) |
| frameDone | input | 1 | Pulse from the consumer: the current frame has been fetched |
| swapAck | output | 1 | One-cycle pulse in the first cycle after a swap |
| bankSel | output | 1 | Current routing: 0 = producer on bank 0 |
| wrAddr | input | ADDR_W | Producer byte address |
| wrWrite | input | 1 | Producer write strobe |
| wrWriteData | input | DATA_W | Producer write data |
| wrWaitReq | output | 1 | Stall back to the producer |
| rdAddr | input | ADDR_W | Consumer byte address |
| rdRead | input | 1 | Consumer read strobe |
| rdBurst | input | BURST_W | Consumer burst length in beats |
| rdReadData | output | DATA_W | Read data returned to the consumer |
| rdDataValid | output | 1 | Read data valid toward the consumer |
| rdWaitReq | output | 1 | Stall back to the consumer |
| b0Addr | output | ADDR_W | Bank 0 address |
| b0Read | output | 1 | Bank 0 read strobe |
| b0Write | output | 1 | Bank 0 write strobe |
| b0WriteData | output | DATA_W | Bank 0 write data |
| b0Burst | output | BURST_W | Bank 0 burst length |
| b0ReadData | input | DATA_W | Bank 0 read data |
| b0DataValid | input | 1 | Bank 0 read data valid |
| b0WaitReq | input | 1 | Bank 0 waitrequest |
| b1Addr | output | ADDR_W | Bank 1 address |
| b1Read | output | 1 | Bank 1 read strobe |
| b1Write | output | 1 | Bank 1 write strobe |
| b1WriteData | output | DATA_W | Bank 1 write data |
| b1Burst | output | BURST_W | Bank 1 burst length |
| b1ReadData | input | DATA_W | Bank 1 read data |
| b1DataValid | input | 1 | Bank 1 read data valid |
| b1WaitReq | input | 1 | Bank 1 waitrequest |

## Verification
A swap request and the return of the last outstanding read beat can fall in the same window. The swap must then wait for the beat and fire on the following edge. The bench provokes this by accepting a three-beat burst, then raising `frameDone` and `swapReq` while beats are still owed, and returning them with gaps. It judges the result by checking that `bankSel` and `swapAck` stay unchanged until the edge after the final beat. A second overlap is between a pending swap and a consumer that holds `rdRead` high. For that case the bench checks that neither bank receives a read strobe, and that both routes move together in the cycle where the acknowledge pulse appears.

// File: rtl/pingpong_router_pkg.sv
package pingpong_router_pkg;
  // Strobes from the control to the datapath
  typedef struct packed {
    logic sel;      // 0: producer on bank 0, consumer on bank 1
    logic rdBlock;  // swap pending: stall the consumer
  } ctrlStrobe_t;

  // Events reported by the datapath to the control
  typedef struct packed {
    logic rdAccept; // consumer read accepted this cycle
    logic rdBeat;   // one read beat returned to the consumer
  } dpStatus_t;
endpackage

// File: rtl/pingpong_router_ctrl.sv
module pingpong_router_ctrl
  import pingpong_router_pkg::*;
#(
  parameter int BURST_W = 7,
  parameter int MAX_OUTSTANDING = 128,
  localparam int CNT_W = $clog2(MAX_OUTSTANDING + 1)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               swapReq,
  input  logic               frameDone,
  input  logic [BURST_W-1:0] rdBurst,
  input  dpStatus_t          status,
  output ctrlStrobe_t        strobe,
  output logic               swapAck
);
  logic             selQ, pendQ, doneQ, ackQ;
  logic [CNT_W-1:0] cntQ, cntNext;
  logic             wantSwap, swapNow;

  assign wantSwap = pendQ | swapReq;
  assign swapNow  = wantSwap & doneQ & (cntQ == '0) & ~status.rdAccept;
  assign cntNext  = cntQ
                  + (status.rdAccept ? CNT_W'(rdBurst) : '0)
                  - (status.rdBeat ? CNT_W'(1) : '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      selQ  <= 1'b0;
      pendQ <= 1'b0;
      doneQ <= 1'b0;
      ackQ  <= 1'b0;
      cntQ  <= '0;
    end else begin
      selQ  <= selQ ^ swapNow;
      pendQ <= wantSwap & ~swapNow;
      doneQ <= (doneQ & ~swapNow) | frameDone;
      ackQ  <= swapNow;
      cntQ  <= cntNext;
    end
  end

  assign strobe.sel     = selQ;
  assign strobe.rdBlock = pendQ;
  assign swapAck        = ackQ;

  // R8: the acknowledge marks exactly the cycle where the route moved
  assert_flip_with_ack_R8: assert property (@(posedge clk) disable iff (!rstN)
    ackQ |-> (selQ != $past(selQ)));

  // R6: routing only moves once nothing is owed to the consumer
  assert_swap_idle_R6: assert property (@(posedge clk) disable iff (!rstN)
    (selQ != $past(selQ)) |-> ($past(cntQ) == '0));

  // R5: routing only moves after the frame has been reported done
  assert_swap_after_done_R5: assert property (@(posedge clk) disable iff (!rstN)
    (selQ != $past(selQ)) |-> $past(doneQ));

  // R6: a returned beat never drives the count below zero
  assert_no_underflow_R6: assert property (@(posedge clk) disable iff (!rstN)
    status.rdBeat |-> (cntQ != '0));
endmodule

// File: rtl/pingpong_router_datapath.sv
module pingpong_router_datapath
  import pingpong_router_pkg::*;
#(
  parameter int ADDR_W  = 27,
  parameter int DATA_W  = 32,
  parameter int BURST_W = 7,
  localparam int NBANK  = 2
) (
  input  logic                            clk,
  input  logic                            rstN,
  input  ctrlStrobe_t                     strobe,
  output dpStatus_t                       status,
  input  logic [ADDR_W-1:0]               wrAddr,
  input  logic                            wrWrite,
  input  logic [DATA_W-1:0]               wrWriteData,
  output logic                            wrWaitReq,
  input  logic [ADDR_W-1:0]               rdAddr,
  input  logic                            rdRead,
  input  logic [BURST_W-1:0]              rdBurst,
  output logic [DATA_W-1:0]               rdReadData,
  output logic                            rdDataValid,
  output logic                            rdWaitReq,
  output logic [NBANK-1:0][ADDR_W-1:0]    bankAddr,
  output logic [NBANK-1:0]                bankRead,
  output logic [NBANK-1:0]                bankWrite,
  output logic [NBANK-1:0][DATA_W-1:0]    bankWriteData,
  output logic [NBANK-1:0][BURST_W-1:0]   bankBurst,
  input  logic [NBANK-1:0][DATA_W-1:0]    bankReadData,
  input  logic [NBANK-1:0]                bankDataValid,
  input  logic [NBANK-1:0]                bankWaitReq
);
  logic rdIdx, wrIdx;
  assign wrIdx = strobe.sel;
  assign rdIdx = ~strobe.sel;

  for (genvar b = 0; b < NBANK; b++) begin : gBank
    logic readerOwns;
    assign readerOwns       = (strobe.sel != 1'(b));
    assign bankAddr[b]      = readerOwns ? rdAddr : wrAddr;
    assign bankRead[b]      = readerOwns & rdRead & ~strobe.rdBlock;
    assign bankWrite[b]     = ~readerOwns & wrWrite;
    assign bankWriteData[b] = wrWriteData;
    assign bankBurst[b]     = readerOwns ? rdBurst : BURST_W'(1);

    // R2: a bank is never read and written in the same cycle
    assert_one_owner_R2: assert property (@(posedge clk) disable iff (!rstN)
      $onehot0({bankRead[b], bankWrite[b]}));
  end

  assign wrWaitReq       = bankWaitReq[wrIdx];
  assign rdWaitReq       = strobe.rdBlock | bankWaitReq[rdIdx];
  assign rdReadData      = bankReadData[rdIdx];
  assign rdDataValid     = bankDataValid[rdIdx];
  assign status.rdAccept = rdRead & ~rdWaitReq;
  assign status.rdBeat   = rdDataValid;

  // R7: no read strobe leaves the router while a swap waits
  assert_block_reader_R7: assert property (@(posedge clk) disable iff (!rstN)
    strobe.rdBlock |-> (bankRead == '0));
endmodule

// File: rtl/pingpong_bank_router.sv
module pingpong_bank_router
  import pingpong_router_pkg::*;
#(
  parameter int ADDR_W          = 27,
  parameter int DATA_W          = 32,
  parameter int BURST_W         = 7,
  parameter int MAX_OUTSTANDING = 128
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               swapReq,
  input  logic               frameDone,
  output logic               swapAck,
  output logic               bankSel,
  input  logic [ADDR_W-1:0]  wrAddr,
  input  logic               wrWrite,
  input  logic [DATA_W-1:0]  wrWriteData,
  output logic               wrWaitReq,
  input  logic [ADDR_W-1:0]  rdAddr,
  input  logic               rdRead,
  input  logic [BURST_W-1:0] rdBurst,
  output logic [DATA_W-1:0]  rdReadData,
  output logic               rdDataValid,
  output logic               rdWaitReq,
  output logic [ADDR_W-1:0]  b0Addr,
  output logic               b0Read,
  output logic               b0Write,
  output logic [DATA_W-1:0]  b0WriteData,
  output logic [BURST_W-1:0] b0Burst,
  input  logic [DATA_W-1:0]  b0ReadData,
  input  logic               b0DataValid,
  input  logic               b0WaitReq,
  output logic [ADDR_W-1:0]  b1Addr,
  output logic               b1Read,
  output logic               b1Write,
  output logic [DATA_W-1:0]  b1WriteData,
  output logic [BURST_W-1:0] b1Burst,
  input  logic [DATA_W-1:0]  b1ReadData,
  input  logic               b1DataValid,
  input  logic               b1WaitReq
);
  ctrlStrobe_t              strobe;
  dpStatus_t                status;
  logic [1:0][ADDR_W-1:0]   bankAddr;
  logic [1:0]               bankRead, bankWrite;
  logic [1:0][DATA_W-1:0]   bankWriteData;
  logic [1:0][BURST_W-1:0]  bankBurst;

  pingpong_router_ctrl #(.BURST_W(BURST_W), .MAX_OUTSTANDING(MAX_OUTSTANDING)) u_ctrl (
    .clk(clk), .rstN(rstN), .swapReq(swapReq), .frameDone(frameDone),
    .rdBurst(rdBurst), .status(status), .strobe(strobe), .swapAck(swapAck)
  );

  pingpong_router_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .BURST_W(BURST_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .status(status),
    .wrAddr(wrAddr), .wrWrite(wrWrite), .wrWriteData(wrWriteData), .wrWaitReq(wrWaitReq),
    .rdAddr(rdAddr), .rdRead(rdRead), .rdBurst(rdBurst), .rdReadData(rdReadData),
    .rdDataValid(rdDataValid), .rdWaitReq(rdWaitReq),
    .bankAddr(bankAddr), .bankRead(bankRead), .bankWrite(bankWrite),
    .bankWriteData(bankWriteData), .bankBurst(bankBurst),
    .bankReadData({b1ReadData, b0ReadData}),
    .bankDataValid({b1DataValid, b0DataValid}),
    .bankWaitReq({b1WaitReq, b0WaitReq})
  );

  assign bankSel     = strobe.sel;
  assign b0Addr      = bankAddr[0];
  assign b0Read      = bankRead[0];
  assign b0Write     = bankWrite[0];
  assign b0WriteData = bankWriteData[0];
  assign b0Burst     = bankBurst[0];
  assign b1Addr      = bankAddr[1];
  assign b1Read      = bankRead[1];
  assign b1Write     = bankWrite[1];
  assign b1WriteData = bankWriteData[1];
  assign b1Burst     = bankBurst[1];
endmodule

// File: tb/pingpong_bank_router_tb.sv
module pingpong_bank_router_tb;
  localparam int ADDR_W = 27, DATA_W = 32, BURST_W = 7;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic swapReq = 0, frameDone = 0, swapAck, bankSel;
  logic [ADDR_W-1:0] wrAddr = '0, rdAddr = '0;
  logic wrWrite = 0, wrWaitReq, rdRead = 0, rdDataValid, rdWaitReq;
  logic [DATA_W-1:0] wrWriteData = '0, rdReadData;
  logic [BURST_W-1:0] rdBurst = BURST_W'(1);
  logic [ADDR_W-1:0] b0Addr, b1Addr;
  logic b0Read, b0Write, b1Read, b1Write;
  logic [DATA_W-1:0] b0WriteData, b1WriteData;
  logic [BURST_W-1:0] b0Burst, b1Burst;
  logic [DATA_W-1:0] b0ReadData = '0, b1ReadData = '0;
  logic b0DataValid = 0, b1DataValid = 0, b0WaitReq = 0, b1WaitReq = 0;

  int checks = 0, errors = 0;
  bit finished = 0;

  always #2 clk = ~clk;  // 250 MHz

  pingpong_bank_router u_dut (
    .clk(clk), .rstN(rstN), .swapReq(swapReq), .frameDone(frameDone),
    .swapAck(swapAck), .bankSel(bankSel),
    .wrAddr(wrAddr), .wrWrite(wrWrite), .wrWriteData(wrWriteData), .wrWaitReq(wrWaitReq),
    .rdAddr(rdAddr), .rdRead(rdRead), .rdBurst(rdBurst), .rdReadData(rdReadData),
    .rdDataValid(rdDataValid), .rdWaitReq(rdWaitReq),
    .b0Addr(b0Addr), .b0Read(b0Read), .b0Write(b0Write), .b0WriteData(b0WriteData),
    .b0Burst(b0Burst), .b0ReadData(b0ReadData), .b0DataValid(b0DataValid), .b0WaitReq(b0WaitReq),
    .b1Addr(b1Addr), .b1Read(b1Read), .b1Write(b1Write), .b1WriteData(b1WriteData),
    .b1Burst(b1Burst), .b1ReadData(b1ReadData), .b1DataValid(b1DataValid), .b1WaitReq(b1WaitReq)
  );

  task automatic chk(input logic [63:0] act, input logic [63:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(bankSel, 0, "R1 bankSel after reset");
    chk(swapAck, 0, "R1 swapAck after reset");
    wrWrite = 1; #1;
    chk(b0Write, 1, "R1 producer on bank 0");
    chk(b1Write, 0, "R1 no producer write on bank 1");
    wrWrite = 0; b1WaitReq = 1; rdRead = 1; #1;
    chk(b1Read, 1, "R1 consumer on bank 1");
    chk(b0Read, 0, "R1 no consumer read on bank 0");
    rdRead = 0; b1WaitReq = 0;
  endtask

  task automatic t_writer_route();
    @(negedge clk);
    wrAddr = 27'h7FFFFFC; wrWriteData = 32'hA5A5_0001; wrWrite = 1; #1;
    chk(b0Addr, 27'h7FFFFFC, "R4 producer address unchanged");
    chk(b0WriteData, 32'hA5A5_0001, "R2 write data on bank 0");
    chk(b0Write, 1, "R2 write strobe on bank 0");
    chk(b1Write, 0, "R2 no write on bank 1");
    b0WaitReq = 1; #1;
    chk(wrWaitReq, 1, "R2 waitrequest from own bank");
    b0WaitReq = 0; b1WaitReq = 1; #1;
    chk(wrWaitReq, 0, "R2 other bank waitrequest ignored");
    b1WaitReq = 0; wrWrite = 0;
  endtask

  task automatic t_reader_route();
    @(negedge clk);
    rdAddr = 27'h10; rdBurst = 4; rdRead = 1; #1;
    chk(b1Read, 1, "R3 read strobe on bank 1");
    chk(b1Burst, 4, "R3 burst length on bank 1");
    chk(b1Addr, 27'h10, "R4 word 4 at byte 0x10");
    chk(b0Read, 0, "R3 no read on bank 0");
    chk(rdWaitReq, 0, "R3 consumer not stalled");
    @(negedge clk);
    rdRead = 0;
    b0DataValid = 1; #1;
    chk(rdDataValid, 0, "R3 other bank valid not passed");
    b0DataValid = 0;
    for (int i = 0; i < 4; i++) begin
      b1DataValid = 1; b1ReadData = 32'hD000 + i; #1;
      chk(rdDataValid, 1, "R3 valid from own bank");
      chk(rdReadData, 32'hD000 + i, "R3 data from own bank");
      @(negedge clk);
    end
    b1DataValid = 0;
  endtask

  task automatic t_swap_needs_done();
    @(negedge clk);
    swapReq = 1;
    @(negedge clk);
    swapReq = 0; rdRead = 1; #1;
    chk(rdWaitReq, 1, "R7 consumer stalled while pending");
    chk(b1Read, 0, "R7 no read to bank 1 while pending");
    chk(b0Read, 0, "R7 no read to bank 0 while pending");
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      chk(swapAck, 0, "R5 no ack before frame done");
      chk(bankSel, 0, "R5 no swap before frame done");
    end
    frameDone = 1;
    @(negedge clk);
    frameDone = 0; b0WaitReq = 1;
    @(negedge clk);
    chk(swapAck, 1, "R8 ack with flip");
    chk(bankSel, 1, "R8 bankSel flipped");
    chk(b0Read, 1, "R8 consumer moved to bank 0");
    chk(b1Read, 0, "R8 consumer left bank 1");
    wrWrite = 1; #1;
    chk(b1Write, 1, "R8 producer moved to bank 1");
    chk(b0Write, 0, "R8 producer left bank 0");
    @(negedge clk);
    chk(swapAck, 0, "R8 ack is one cycle");
    rdRead = 0; wrWrite = 0; b0WaitReq = 0;
  endtask

  task automatic t_swap_needs_idle();
    @(negedge clk);
    rdBurst = 3; rdRead = 1;
    @(negedge clk);
    rdRead = 0; frameDone = 1; swapReq = 1;
    @(negedge clk);
    frameDone = 0; swapReq = 0;
    for (int i = 0; i < 2; i++) begin
      b0DataValid = 1;
      @(negedge clk);
      chk(swapAck, 0, "R6 no ack with beats owed");
      chk(bankSel, 1, "R6 no swap with beats owed");
    end
    b0DataValid = 0;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk(bankSel, 1, "R6 still waiting for last beat");
    end
    b0DataValid = 1;
    @(negedge clk);
    b0DataValid = 0;
    chk(swapAck, 0, "R6 no ack on last beat edge");
    @(negedge clk);
    chk(swapAck, 1, "R6 ack after count empties");
    chk(bankSel, 0, "R6 swapped after count empties");
  endtask

  task automatic t_done_cleared();
    @(negedge clk);
    swapReq = 1;
    @(negedge clk);
    swapReq = 0;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      chk(bankSel, 0, "R10 old frame done not reused");
      chk(swapAck, 0, "R10 no ack without new frame done");
    end
    frameDone = 1;
    @(negedge clk);
    frameDone = 0;
    @(negedge clk);
    chk(swapAck, 1, "R10 ack after new frame done");
    chk(bankSel, 1, "R10 swapped after new frame done");
  endtask

  task automatic t_immediate();
    @(negedge clk);
    frameDone = 1;
    @(negedge clk);
    frameDone = 0;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk(bankSel, 1, "R9 frame done alone does not swap");
    end
    swapReq = 1;
    @(negedge clk);
    swapReq = 0;
    chk(swapAck, 1, "R9 ack one edge after request");
    chk(bankSel, 0, "R9 swap one edge after request");
    @(negedge clk);
    chk(swapAck, 0, "R9 ack dropped");
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1;
    t_reset();
    t_writer_route();
    t_reader_route();
    t_swap_needs_done();
    t_swap_needs_idle();
    t_done_cleared();
    t_immediate();
    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule